// File: doc/BRIEF.md
# Indexed DDC Data Buffer Port

This block is a small byte store that a host processor and an I2C transfer engine share. The host never addresses the store directly. It goes through one 32-bit data window that holds a pointer. A window write can load the pointer from an index field. A window write in the write direction stores a byte and then steps the pointer. A window read returns a byte through a one-deep prefetch register and then steps the pointer.

To set up a transfer, the host writes address bytes and outgoing payload bytes in sequence. For each expected inbound message it moves the pointer past the slots that the engine will fill. After the engine is done, the host reloads the pointer for the read direction. It drops the first value it reads, because the prefetch register still holds an older byte. The reads after that return the stored bytes in order.

The engine has its own port. It reads bytes at any address without waiting a cycle, and it writes a byte at any address. Any engine access in a cycle overrides the host window for that cycle.

Top module: `ddc_data_port`

## Requirements
- R1: After reset, every byte of the store is 0x00, the pointer is 0, the prefetch register is 0x00 and `host_rdata_o` is 0.
- R2: The window word is laid out as follows. The data byte is bits [7:0]. Bit 8 is the direction: 0 means write and 1 means read. The index is bits [23:16], and only its value modulo the depth is used. Bit 31 is index-load. On `host_rdata_o`, bits [31:8] always read 0.
- R3: A host write with index-load set loads the pointer from the index field. If its direction is write, the data byte is stored at the newly loaded pointer.
- R4: Each host write in the write direction stores its byte at the current pointer and then advances the pointer by one.
- R5: The pointer wraps modulo the depth (64), for writes and for reads.
- R6: A host read puts the current prefetch byte onto `host_rdata_o`. It then refills the prefetch register from the pointer's slot and advances the pointer. A read strobe that comes in the same cycle as a write strobe is ignored. `host_rdata_o` only changes on an accepted read.
- R7: A host write in the read direction with index-load clear stores nothing and leaves the pointer and `host_rdata_o` unchanged.
- R8: An engine write stores `eng_wdata_i` at `eng_waddr_i` on the clock edge. `eng_rdata_o` shows the byte stored at `eng_raddr_i` in the same cycle.
- R9: In any cycle where `eng_we_i` or `eng_re_i` is high, host strobes are ignored. Nothing is stored for the host, and the pointer and the read path stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host window write strobe |
| host_rd_i | input | 1 | Host window read strobe |
| host_wdata_i | input | 32 | Host window write word |
| host_rdata_o | output | 32 | Host window read word |
| eng_re_i | input | 1 | Engine read access marker |
| eng_raddr_i | input | ADDR_W (6) | Engine read address |
| eng_rdata_o | output | 8 | Engine read byte |
| eng_we_i | input | 1 | Engine write strobe |
| eng_waddr_i | input | ADDR_W (6) | Engine write address |
| eng_wdata_i | input | 8 | Engine write byte |

## Verification
The host writes a full sweep of 64 bytes plus one more. This shows whether the pointer steps once per stored byte and wraps back onto slot 0. Read bursts begin at slot 0, at an interior slot and at the last two slots. These bursts tell the discarded stale byte apart from the real stream and show whether wrap works on the read side. Several kinds of write are compared against a plain data write: writes with a loaded index, read-direction writes with and without index-load, and index values above the depth. This shows that each kind moves the pointer on its own terms. Host strobes that collide with engine reads, with engine writes and with a second host strobe show that the ignored access leaves no trace.

// File: rtl/ddc_buf_pkg.sv
package ddc_buf_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned DIR_BIT   = 8;
  localparam int unsigned IDX_LSB   = 16;
  localparam int unsigned IDX_W     = 8;
  localparam int unsigned IDXLD_BIT = 31;

  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } dir_e;

  typedef struct packed {
    logic              idx_ld;
    logic [IDX_W-1:0]  idx;
    dir_e              dir;
    logic [BYTE_W-1:0] data;
  } win_word_t;

  function automatic win_word_t decode_word(input logic [WORD_W-1:0] w);
    win_word_t r;
    r.idx_ld = w[IDXLD_BIT];
    r.idx    = w[IDX_LSB +: IDX_W];
    r.dir    = dir_e'(w[DIR_BIT]);
    r.data   = w[BYTE_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/ddc_buf_mem.sv
module ddc_buf_mem #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eng_we_i,
  input  logic [AW-1:0]     eng_waddr_i,
  input  logic [BYTE_W-1:0] eng_wdata_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_waddr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  input  logic [AW-1:0]     eng_raddr_i,
  output logic [BYTE_W-1:0] eng_rdata_o,
  input  logic [AW-1:0]     host_raddr_i,
  output logic [BYTE_W-1:0] host_rdata_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (eng_we_i) begin
      mem_q[eng_waddr_i] <= eng_wdata_i;
    end else if (host_we_i) begin
      mem_q[host_waddr_i] <= host_wdata_i;
    end
  end

  assign eng_rdata_o  = mem_q[eng_raddr_i];
  assign host_rdata_o = mem_q[host_raddr_i];

  AST_ENG_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we_i |=> mem_q[$past(eng_waddr_i)] == $past(eng_wdata_i)); // R8
  AST_SINGLE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_we_i && host_we_i)); // R9
endmodule

// File: rtl/ddc_buf_ptr.sv
module ddc_buf_ptr #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_acc_i,
  input  logic          rd_acc_i,
  input  logic          idx_ld_i,
  input  logic          dir_rd_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] ptr_o,
  output logic          st_en_o,
  output logic [AW-1:0] st_addr_o
);
  logic [AW-1:0] ptr_q, ptr_d, base;

  assign base      = (wr_acc_i && idx_ld_i) ? idx_i : ptr_q;
  assign st_en_o   = wr_acc_i && !dir_rd_i;
  assign st_addr_o = base;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_acc_i) ptr_d = dir_rd_i ? base : base + 1'b1;
    else if (rd_acc_i) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc_i && idx_ld_i && dir_rd_i) |=> ptr_q == $past(idx_i)); // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc_i && !idx_ld_i && !dir_rd_i) |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R4
  AST_PTR_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc_i && !idx_ld_i && dir_rd_i) |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/ddc_buf_rdpath.sv
module ddc_buf_rdpath #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_acc_i,
  input  logic [BYTE_W-1:0] fill_i,
  output logic [BYTE_W-1:0] rbyte_o
);
  logic [BYTE_W-1:0] pf_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q  <= '0;
      out_q <= '0;
    end else if (rd_acc_i) begin
      out_q <= pf_q;
      pf_q  <= fill_i;
    end
  end

  assign rbyte_o = out_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc_i |=> $stable(rbyte_o)); // R6
endmodule

// File: rtl/ddc_data_port.sv
module ddc_data_port
  import ddc_buf_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              eng_re_i,
  input  logic [ADDR_W-1:0] eng_raddr_i,
  output logic [BYTE_W-1:0] eng_rdata_o,
  input  logic              eng_we_i,
  input  logic [ADDR_W-1:0] eng_waddr_i,
  input  logic [BYTE_W-1:0] eng_wdata_i
);
  win_word_t         w;
  logic              eng_act, wr_acc, rd_acc, st_en;
  logic [ADDR_W-1:0] ptr, st_addr;
  logic [BYTE_W-1:0] fill, rbyte;
  logic              unused_bits;

  assign w           = decode_word(host_wdata_i);
  assign unused_bits = ^{w.idx, host_wdata_i[15:9], host_wdata_i[30:24]};
  assign eng_act     = eng_we_i || eng_re_i;
  assign wr_acc      = host_wr_i && !eng_act;
  assign rd_acc      = host_rd_i && !host_wr_i && !eng_act;

  ddc_buf_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni,
    .wr_acc_i (wr_acc),
    .rd_acc_i (rd_acc),
    .idx_ld_i (w.idx_ld),
    .dir_rd_i (w.dir == DIR_RD),
    .idx_i    (w.idx[ADDR_W-1:0]),
    .ptr_o    (ptr),
    .st_en_o  (st_en),
    .st_addr_o(st_addr)
  );

  ddc_buf_mem #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_mem (
    .clk_i, .rst_ni,
    .eng_we_i, .eng_waddr_i, .eng_wdata_i,
    .host_we_i   (st_en),
    .host_waddr_i(st_addr),
    .host_wdata_i(w.data),
    .eng_raddr_i,
    .eng_rdata_o,
    .host_raddr_i(ptr),
    .host_rdata_o(fill)
  );

  ddc_buf_rdpath #(.BYTE_W(BYTE_W)) u_rd (
    .clk_i, .rst_ni,
    .rd_acc_i(rd_acc),
    .fill_i  (fill),
    .rbyte_o (rbyte)
  );

  assign host_rdata_o = {{(WORD_W-BYTE_W){1'b0}}, rbyte};

  AST_ENG_HOLDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_act |=> $stable(ptr)); // R9
  AST_ENG_HOLDS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_act |=> $stable(host_rdata_o)); // R9
endmodule

// File: tb/ddc_data_port_tb.sv
module ddc_data_port_tb;
  logic        clk_i = 0, rst_ni = 0;
  logic        host_wr_i = 0, host_rd_i = 0;
  logic [31:0] host_wdata_i = '0, host_rdata_o;
  logic        eng_re_i = 0, eng_we_i = 0;
  logic [5:0]  eng_raddr_i = '0, eng_waddr_i = '0;
  logic [7:0]  eng_rdata_o, eng_wdata_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_mem [64];
  logic [5:0] m_ptr;
  logic [7:0] m_pf, m_out;

  ddc_data_port u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit ld, input logic [7:0] idx, input bit rd, input logic [7:0] d);
    return {ld, 7'b0, idx, 7'b0, rd, d};
  endfunction

  // accepted host write; model per R3/R4/R7
  task automatic hw(input bit ld, input logic [7:0] idx, input bit rd, input logic [7:0] d);
    @(negedge clk_i);
    host_wr_i = 1; host_wdata_i = mk(ld, idx, rd, d);
    @(negedge clk_i);
    host_wr_i = 0;
    if (ld) m_ptr = idx[5:0];
    if (!rd) begin m_mem[m_ptr] = d; m_ptr = m_ptr + 1; end
  endtask

  task automatic hr(input string tag);
    @(negedge clk_i);
    host_rd_i = 1;
    @(negedge clk_i);
    host_rd_i = 0;
    m_out = m_pf; m_pf = m_mem[m_ptr]; m_ptr = m_ptr + 1;
    chk(host_rdata_o == {24'b0, m_out}, tag, host_rdata_o, m_out);
  endtask

  task automatic peek(input logic [5:0] a, input string tag);
    eng_raddr_i = a;
    #1;
    chk(eng_rdata_o == m_mem[a], tag, eng_rdata_o, m_mem[a]);
  endtask

  task automatic ew(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i);
    eng_we_i = 1; eng_waddr_i = a; eng_wdata_i = d;
    @(negedge clk_i);
    eng_we_i = 0;
    m_mem[a] = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] keep;
    for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
    m_ptr = 0; m_pf = 0; m_out = 0;
    #35 rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(host_rdata_o == 0, "R1 rdata", host_rdata_o, 0);
    peek(0, "R1 mem0"); peek(31, "R1 mem31"); peek(63, "R1 mem63");

    // R4 full sweep, R5 wrap back to 0
    hw(1, 8'd0, 0, 8'd3);
    for (int i = 1; i < 64; i++) hw(0, 0, 0, 8'(i * 7 + 3));
    for (int i = 0; i < 64; i++) peek(6'(i), "R4 sweep");
    hw(0, 0, 0, 8'hEE);
    chk(m_ptr == 1, "R5 model", m_ptr, 1);
    peek(0, "R5 wrap store");

    // R3 index load with data, then R4 step
    hw(1, 8'd20, 0, 8'hA5); peek(20, "R3 load+store");
    hw(0, 0, 0, 8'h5A);     peek(21, "R4 step after load");
    // R2 index modulo depth
    hw(1, 8'h45, 0, 8'h77); peek(5, "R2 index mod");
    hw(0, 0, 0, 8'h78);     peek(6, "R2 next");

    // R6 read bursts, first value stale; R5 wrap on reads; R2 upper zero
    foreach (keep[k]) ;
    hw(1, 8'd0, 1, 8'h00); hr("R6 stale"); for (int j = 0; j < 4; j++) hr("R6 burst0");
    hw(1, 8'd10, 1, 8'h00); hr("R6 stale"); for (int j = 0; j < 4; j++) hr("R6 burst10");
    hw(1, 8'd62, 1, 8'h00); hr("R6 stale"); for (int j = 0; j < 4; j++) hr("R5 read wrap");

    // R7 read-direction write without load: nothing stored, ptr and rdata kept
    keep = m_out;
    hw(1, 8'd30, 0, 8'h11);
    hw(0, 8'd5, 1, 8'h99);
    chk(host_rdata_o == {24'b0, keep}, "R7 rdata", host_rdata_o, keep);
    peek(5, "R7 no store idx"); peek(31, "R7 no store ptr");
    hw(0, 0, 0, 8'h33); peek(31, "R7 ptr kept");

    // R8 engine writes and reads
    for (int i = 0; i < 8; i++) begin
      ew(6'(40 + i), 8'(8'hC0 + i));
      peek(6'(40 + i), "R8 eng wr");
    end

    // R9 host write blocked by engine read
    @(negedge clk_i);
    host_wr_i = 1; host_wdata_i = mk(0, 0, 0, 8'hBD); eng_re_i = 1;
    @(negedge clk_i);
    host_wr_i = 0; eng_re_i = 0;
    peek(32, "R9 blocked store");
    hw(0, 0, 0, 8'h44); peek(32, "R9 ptr kept");
    // R9 host write and engine write same cycle: engine wins, ptr held
    @(negedge clk_i);
    host_wr_i = 1; host_wdata_i = mk(0, 0, 0, 8'h55);
    eng_we_i = 1; eng_waddr_i = 6'(m_ptr); eng_wdata_i = 8'h66;
    @(negedge clk_i);
    host_wr_i = 0; eng_we_i = 0;
    m_mem[m_ptr] = 8'h66;
    peek(m_ptr, "R9 engine wins");
    hw(0, 0, 0, 8'h67); peek(m_ptr - 1, "R9 ptr kept2");
    // R9 host read blocked by engine
    keep = m_out;
    @(negedge clk_i);
    host_rd_i = 1; eng_re_i = 1;
    @(negedge clk_i);
    host_rd_i = 0; eng_re_i = 0;
    chk(host_rdata_o == {24'b0, keep}, "R9 read blocked", host_rdata_o, keep);

    // R6 read with simultaneous write ignored
    hw(1, 8'd40, 1, 8'h00); hr("R6 stale"); hr("R6 pre");
    keep = m_out;
    @(negedge clk_i);
    host_rd_i = 1; host_wr_i = 1; host_wdata_i = mk(0, 0, 0, 8'h9C);
    @(negedge clk_i);
    host_rd_i = 0; host_wr_i = 0;
    m_mem[m_ptr] = 8'h9C; m_ptr = m_ptr + 1;
    chk(host_rdata_o == {24'b0, keep}, "R6 rd with wr", host_rdata_o, keep);
    peek(42, "R6 wr wins");
    hr("R6 after collide");

    finish_run();
  end
endmodule